// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Detector

This block watches eight already-selected, already-synchronised input lines and raises one interrupt request per line. Each channel runs either edge-sensitive, where an enabled rising or falling transition latches a pending flag that software must clear, or level-sensitive, where the request simply follows the line while it sits at a programmed active level. A small register port with a single write strobe and a combinational read path lets software configure the channels, inspect sticky transition records and acknowledge interrupts.

The two per-channel enable registers take a different meaning in each mode. In edge mode the "R" enable arms rising transitions and the "F" enable arms falling ones. In level mode the "R" enable gates the request and the "F" enable holds the active level (1 means high). Both enables can be written whole or changed bit by bit through dedicated set and clear addresses. Writing a 1 to a status bit acknowledges a pending edge, or on a level channel inverts its active level, which is the usual way to catch the line's return to idle.

Top module: `pin_irq_unit`

## Requirements
- R1: After a synchronous reset every register reads 0 and irq_o is 0.
- R2: Register addresses are 0 mode (bit n = 1 makes channel n level-sensitive), 1 enable-R, 4 enable-F, 7 rise record, 8 fall record, 9 status; writes to 0, 1 and 4 load the register whole, and reads of 2, 3, 5 and 6 return the enable register they modify.
- R3: A write to address 2 (or 5) ORs the write data into enable-R (or enable-F); a write to address 3 (or 6) clears the bits set in the write data; other bits are unchanged.
- R4: A change of line n from 0 to 1 (or 1 to 0) between two consecutive clocks sets rise (or fall) record bit n at the second clock, whatever the mode and enables; writing 1 to a record bit clears it, and a new edge in the same cycle as its clear leaves the bit set.
- R5: On an edge channel, an edge whose enable bit is set sets status bit n at the clock that sees the edge; it stays set until a status write with bit n = 1; disabled edges leave status unchanged.
- R6: On a level channel, status bit n equals enable-R bit n AND (line n equal to enable-F bit n), following the line with no latching.
- R7: A status write with bit n = 1 on a level channel inverts enable-F bit n; on an edge channel it clears the pending flag.
- R8: irq_o equals the status register at all times.
- R9: Making a channel level-sensitive discards its pending edge flag, so returning it to edge mode shows status 0 until a new enabled edge.
- R10: Addresses 10 to 15 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_CH | Selected, synchronised input lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (read and write) |
| reg_wdata | input | NUM_CH | Write data |
| reg_rdata | output | NUM_CH | Read data for reg_addr, combinational |
| irq_o | output | NUM_CH | Interrupt request per channel |

## Verification
The bench drives an edge at the very cycle its record bit is being cleared; a design that lets the clear win would lose that event and read 0. It toggles a level channel's active level through the status register and checks the enable-F readback and the request, which catches a design that clears instead of inverting. It also flips a channel with a pending edge into level mode and back, where a design that keeps the stale flag would raise a request with no new edge, and it checks that disabled edges are still recorded in the rise and fall registers while leaving status untouched.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE    = 4'd0,
        A_ENR     = 4'd1,
        A_ENR_SET = 4'd2,
        A_ENR_CLR = 4'd3,
        A_ENF     = 4'd4,
        A_ENF_SET = 4'd5,
        A_ENF_CLR = 4'd6,
        A_RISE    = 4'd7,
        A_FALL    = 4'd8,
        A_STAT    = 4'd9
    } reg_addr_e;

    // One strobe per register action; at most one is high in a cycle.
    typedef struct packed {
        logic mode_ld;
        logic enr_ld;
        logic enr_set;
        logic enr_clr;
        logic enf_ld;
        logic enf_set;
        logic enf_clr;
        logic rise_clr;
        logic fall_clr;
        logic stat_wr;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic we, input logic [ADDR_W-1:0] addr);
        wr_dec_t d;
        d = '0;
        if (we) begin
            case (addr)
                A_MODE:    d.mode_ld  = 1'b1;
                A_ENR:     d.enr_ld   = 1'b1;
                A_ENR_SET: d.enr_set  = 1'b1;
                A_ENR_CLR: d.enr_clr  = 1'b1;
                A_ENF:     d.enf_ld   = 1'b1;
                A_ENF_SET: d.enf_set  = 1'b1;
                A_ENF_CLR: d.enf_clr  = 1'b1;
                A_RISE:    d.rise_clr = 1'b1;
                A_FALL:    d.fall_clr = 1'b1;
                A_STAT:    d.stat_wr  = 1'b1;
                default:   d = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/pin_irq_enreg.sv
module pin_irq_enreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         set,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] tog,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= wdata;
        else if (set)   q <= q | wdata;
        else if (clr)   q <= q & ~wdata;
        else            q <= q ^ tog;
    end

    // R3: set only adds bits, clear only removes them
    p_set_adds_r3: assert property (@(posedge clk) disable iff (rst)
        set |=> ((q & $past(wdata)) == $past(wdata)) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
    p_clr_removes_r3: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((q & $past(wdata)) == '0) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs import pin_irq_pkg::*; #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_dec_t           dec,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] mode_q,
    output logic [NUM_CH-1:0] enr_q,
    output logic [NUM_CH-1:0] enf_q
);

    logic [NUM_CH-1:0] enf_tog;
    logic [NUM_CH-1:0] no_tog;

    assign no_tog  = '0;
    // status writes invert the active level of level channels only
    assign enf_tog = dec.stat_wr ? (wdata & mode_q) : '0;

    always_ff @(posedge clk) begin
        if (rst)              mode_q <= '0;
        else if (dec.mode_ld) mode_q <= wdata;
    end

    pin_irq_enreg #(.W(NUM_CH)) u_enr (
        .clk(clk), .rst(rst),
        .load(dec.enr_ld), .set(dec.enr_set), .clr(dec.enr_clr),
        .wdata(wdata), .tog(no_tog), .q(enr_q)
    );

    pin_irq_enreg #(.W(NUM_CH)) u_enf (
        .clk(clk), .rst(rst),
        .load(dec.enf_ld), .set(dec.enf_set), .clr(dec.enf_clr),
        .wdata(wdata), .tog(enf_tog), .q(enf_q)
    );

    // R7: a status write flips exactly the level-channel bits written with 1
    p_level_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        dec.stat_wr |=> ((enf_q ^ $past(enf_q)) == ($past(wdata) & $past(mode_q))));

endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pins_i,
    input  logic [NUM_CH-1:0] rise_clr,
    input  logic [NUM_CH-1:0] fall_clr,
    output logic [NUM_CH-1:0] rise_pls,
    output logic [NUM_CH-1:0] fall_pls,
    output logic [NUM_CH-1:0] rise_q,
    output logic [NUM_CH-1:0] fall_q
);

    logic [NUM_CH-1:0] prev_q;

    assign rise_pls = pins_i & ~prev_q;
    assign fall_pls = ~pins_i & prev_q;

    // during reset the previous sample tracks the lines, so no edge is seen on release
    always_ff @(posedge clk) begin
        prev_q <= pins_i;
        if (rst) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= (rise_q & ~rise_clr) | rise_pls;
            fall_q <= (fall_q & ~fall_clr) | fall_pls;
        end
    end

    // R4: every observed transition is recorded one clock later
    p_rise_seen_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(pins_i & ~prev_q) & ~rise_q) == '0));
    p_fall_seen_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(~pins_i & prev_q) & ~fall_q) == '0));
    // R4: a record bit only drops when cleared
    p_rise_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (|(rise_q & ~rise_clr)) |=> (($past(rise_q & ~rise_clr) & ~rise_q) == '0));

endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pins_i,
    input  logic [NUM_CH-1:0] mode_q,
    input  logic [NUM_CH-1:0] enr_q,
    input  logic [NUM_CH-1:0] enf_q,
    input  logic [NUM_CH-1:0] rise_pls,
    input  logic [NUM_CH-1:0] fall_pls,
    input  logic [NUM_CH-1:0] stat_clr,
    output logic [NUM_CH-1:0] status
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic pend_q;
        logic hit;
        logic lvl_active;

        assign hit        = (rise_pls[i] & enr_q[i]) | (fall_pls[i] & enf_q[i]);
        assign lvl_active = enr_q[i] & (pins_i[i] == enf_q[i]);

        always_ff @(posedge clk) begin
            if (rst || mode_q[i]) pend_q <= 1'b0;
            else                  pend_q <= (pend_q & ~stat_clr[i]) | hit;
        end

        assign status[i] = mode_q[i] ? lvl_active : pend_q;

        // R5: a pending edge holds until acknowledged
        p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (!mode_q[i] && pend_q && !stat_clr[i]) |=> pend_q);
        // R9: level mode discards the edge flag
        p_mode_flush_r9: assert property (@(posedge clk) disable iff (rst)
            mode_q[i] |=> !pend_q);
        // R6: a disabled level channel never requests
        p_level_gate_r6: assert property (@(posedge clk) disable iff (rst)
            (mode_q[i] && !enr_q[i]) |-> !status[i]);
    end

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit import pin_irq_pkg::*; #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pins_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NUM_CH-1:0] reg_wdata,
    output logic [NUM_CH-1:0] reg_rdata,
    output logic [NUM_CH-1:0] irq_o
);

    wr_dec_t           dec;
    logic [NUM_CH-1:0] mode_q, enr_q, enf_q;
    logic [NUM_CH-1:0] rise_pls, fall_pls, rise_q, fall_q;
    logic [NUM_CH-1:0] rise_clr, fall_clr, stat_clr;
    logic [NUM_CH-1:0] status;

    assign dec      = decode_wr(reg_we, reg_addr);
    assign rise_clr = dec.rise_clr ? reg_wdata : '0;
    assign fall_clr = dec.fall_clr ? reg_wdata : '0;
    assign stat_clr = dec.stat_wr  ? reg_wdata : '0;

    pin_irq_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst(rst), .dec(dec), .wdata(reg_wdata),
        .mode_q(mode_q), .enr_q(enr_q), .enf_q(enf_q)
    );

    pin_irq_edge #(.NUM_CH(NUM_CH)) u_edge (
        .clk(clk), .rst(rst), .pins_i(pins_i),
        .rise_clr(rise_clr), .fall_clr(fall_clr),
        .rise_pls(rise_pls), .fall_pls(fall_pls),
        .rise_q(rise_q), .fall_q(fall_q)
    );

    pin_irq_chan #(.NUM_CH(NUM_CH)) u_chan (
        .clk(clk), .rst(rst), .pins_i(pins_i),
        .mode_q(mode_q), .enr_q(enr_q), .enf_q(enf_q),
        .rise_pls(rise_pls), .fall_pls(fall_pls),
        .stat_clr(stat_clr), .status(status)
    );

    always_comb begin
        case (reg_addr)
            A_MODE:                        reg_rdata = mode_q;
            A_ENR, A_ENR_SET, A_ENR_CLR:   reg_rdata = enr_q;
            A_ENF, A_ENF_SET, A_ENF_CLR:   reg_rdata = enf_q;
            A_RISE:                        reg_rdata = rise_q;
            A_FALL:                        reg_rdata = fall_q;
            A_STAT:                        reg_rdata = status;
            default:                       reg_rdata = '0;
        endcase
    end

    assign irq_o = status;

    // R8: the request seen on irq_o is what software reads as status
    p_irq_is_status_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_STAT) |-> (reg_rdata == irq_o));
    // R10: unmapped addresses read as zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr > A_STAT) |-> (reg_rdata == '0));

endmodule

// File: tb/test_pin_irq_unit.sv
module test_pin_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pins = '0;
    logic         reg_we = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic [N-1:0] irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [3:0] MODE = 4'd0, ENR = 4'd1, ENRS = 4'd2, ENRC = 4'd3,
                           ENF = 4'd4, ENFS = 4'd5, ENFC = 4'd6,
                           RISE = 4'd7, FALL = 4'd8, STAT = 4'd9;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_unit #(.NUM_CH(N)) i_pin_irq_unit (
        .clk(clk), .rst(rst), .pins_i(pins), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [N-1:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, $sformatf("read addr %0d", a), reg_rdata, exp);
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        pins = v;
        @(negedge clk);
    endtask

    task automatic clean;
        set_pins('0);
        wr(MODE, '0); wr(ENR, '0); wr(ENF, '0);
        wr(RISE, '1); wr(FALL, '1); wr(STAT, '1);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 10; a++) rd_check("R1", 4'(a), '0);
        check("R1", "irq after reset", irq_o, '0);
    endtask

    task automatic t_regs;
        wr(MODE, 8'hA5); rd_check("R2", MODE, 8'hA5);
        wr(ENR, 8'h3C);  rd_check("R2", ENR, 8'h3C);
        rd_check("R2", ENRC, 8'h3C);
        wr(ENF, 8'h0F);  rd_check("R2", ENF, 8'h0F);
        rd_check("R2", ENFS, 8'h0F);
        clean();
    endtask

    task automatic t_setclr;
        wr(ENR, 8'h11);  wr(ENRS, 8'h06); rd_check("R3", ENR, 8'h17);
        wr(ENRC, 8'h11); rd_check("R3", ENR, 8'h06);
        wr(ENF, 8'h80);  wr(ENFS, 8'h01); rd_check("R3", ENF, 8'h81);
        wr(ENFC, 8'h80); rd_check("R3", ENF, 8'h01);
        clean();
    endtask

    task automatic t_detect;
        set_pins(8'h81);
        rd_check("R4", RISE, 8'h81);
        rd_check("R4", FALL, 8'h00);
        rd_check("R5", STAT, 8'h00);   // edges on disabled channels raise nothing
        set_pins(8'h01);
        rd_check("R4", FALL, 8'h80);
        wr(RISE, 8'h01);
        rd_check("R4", RISE, 8'h80);
        // edge on line 0 in the very cycle its record bit is cleared
        set_pins(8'h00);
        wr(RISE, 8'hFF);
        @(negedge clk);
        pins = 8'h01; reg_we = 1'b1; reg_addr = RISE; reg_wdata = 8'h01;
        @(negedge clk);
        reg_we = 1'b0;
        rd_check("R4", RISE, 8'h01);
        clean();
    endtask

    task automatic t_edge;
        wr(ENR, 8'h0F); wr(ENF, 8'hF0);
        set_pins(8'hFF);
        rd_check("R5", STAT, 8'h0F);
        check("R8", "irq after rise", irq_o, 8'h0F);
        repeat (2) @(negedge clk);
        rd_check("R5", STAT, 8'h0F);
        set_pins(8'h00);
        rd_check("R5", STAT, 8'hFF);
        wr(STAT, 8'h03);
        rd_check("R7", STAT, 8'hFC);
        check("R8", "irq after ack", irq_o, 8'hFC);
        clean();
    endtask

    task automatic t_level;
        wr(MODE, 8'h0F); wr(ENR, 8'h03); wr(ENF, 8'h01);
        rd_check("R6", STAT, 8'h02);      // ch0 wants high, ch1 wants low, lines low
        set_pins(8'h03);
        rd_check("R6", STAT, 8'h01);
        rd_check("R4", RISE, 8'h03);      // recorded in level mode too
        set_pins(8'h07);
        rd_check("R6", STAT, 8'h01);      // ch2 disabled
        wr(STAT, 8'h01);
        rd_check("R7", ENF, 8'h00);
        rd_check("R6", STAT, 8'h00);
        wr(STAT, 8'h02);
        rd_check("R7", ENF, 8'h02);
        check("R8", "irq level", irq_o, 8'h02);
        clean();
    endtask

    task automatic t_switch;
        wr(ENR, 8'h01);
        set_pins(8'h01);
        rd_check("R5", STAT, 8'h01);
        wr(MODE, 8'h01);                  // level, active low, line high
        rd_check("R9", STAT, 8'h00);
        wr(MODE, 8'h00);
        rd_check("R9", STAT, 8'h00);
        clean();
    endtask

    task automatic t_unmapped;
        wr(MODE, 8'h30);
        rd_check("R10", 4'd12, 8'h00);
        wr(4'd13, 8'hFF);
        rd_check("R10", MODE, 8'h30);
        rd_check("R10", ENR, 8'h00);
        rd_check("R10", ENF, 8'h00);
        rd_check("R10", RISE, 8'h00);
        clean();
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_setclr();
        t_detect();
        t_edge();
        t_level();
        t_switch();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule